// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial bit clock of an SPI master from its parent clock. Each direction, transmit and receive, has its own channel. A channel has a 16-bit scale code and an enable. The scale code packs a coarse prescale value in its upper byte and a power-of-two exponent in its three lowest bits. The exponent value 7 is set aside to pass the parent clock straight through, which gives divide-by-1.

A channel accepts its scale code on the first parent clock edge at which its enable is seen high. From then on it counts half periods. It drives a serial clock level, a rise strobe and a fall strobe, and a one-per-bit tick. A shifter running on the parent clock can use these strobes as clock enables. The strobes are high in the cycle just before the serial clock changes, so a shifter using them updates on the same parent edge as the serial clock. Dropping the enable returns the channel to idle on the next edge. Software picks the code for a wanted frequency. A parameter lets the receive channel reuse the transmit code and enable.

Top module: `spi_sck_prescaler`

## Requirements
- R1: A code whose bits [2:0] equal 7 selects bypass, and the upper byte is ignored. While running in bypass, the tick is high every cycle and the rise and fall strobes stay low. From the second running cycle on, the serial clock output follows the parent clock; it is low in the first running cycle.
- R2: For any other code, the divide ratio is (code[15:8] + 1) × 2^(code[2:0] + 1), and bits [7:3] have no effect. For example, code 0x00F9 divides by 4 and code 0x0506 divides by 768.
- R3: Codes 0x0000 to 0x0004 divide by 2, 4, 8, 16 and 32. Codes 0x1F00 to 0x1F04 divide by 64, 128, 256, 512 and 1024.
- R4: For a ratio N of 2 or more, let H = N/2 and let edge 0 be the accepting edge. The serial clock is low after edge 0 and rises on edge H. After that it toggles every H edges, giving a 50% duty cycle.
- R5: The rise strobe is high in the single cycle before each rising edge of the serial clock, and the fall strobe in the single cycle before each falling edge. The two strobes are never high together. For ratios of 2 or more, the tick coincides with the fall strobe.
- R6: On the first edge at which the enable is low, and after reset, the serial clock is low and the tick and both strobes are low. They stay that way while the enable is low, whatever the scale code does. The next enable restarts the count from zero.
- R7: A change of the scale code while the enable stays high has no effect on the clock pattern. Only the code present at the accepting edge is used.
- R8: The transmit and receive channels run independently with their own codes and enables. When the parameter SHARE_SCALE is 1, the receive channel uses the transmit code and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit channel enable; high runs the clock |
| tx_scale_i | input | 16 | Transmit scale code |
| rx_en_i | input | 1 | Receive channel enable |
| rx_scale_i | input | 16 | Receive scale code |
| tx_sck_o | output | 1 | Transmit serial clock level, idle low |
| tx_tick_o | output | 1 | Transmit one-per-bit enable pulse |
| tx_rise_o | output | 1 | Transmit strobe before a rising serial clock edge |
| tx_fall_o | output | 1 | Transmit strobe before a falling serial clock edge |
| rx_sck_o | output | 1 | Receive serial clock level, idle low |
| rx_tick_o | output | 1 | Receive one-per-bit enable pulse |
| rx_rise_o | output | 1 | Receive strobe before a rising serial clock edge |
| rx_fall_o | output | 1 | Receive strobe before a falling serial clock edge |

## Verification
The properties assume that enables and scale codes change only between parent clock edges. They also assume that nothing watches the serial clock output at a parent edge in bypass, where that output is the parent clock itself and is seen low at every edge. The stimulus changes all inputs on the falling parent edge. It compares outputs in the high phase after each rising edge, which is where the bypass clock is seen high. Codes are changed only while a channel is idle, or on purpose mid-frame to show they are ignored.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int unsigned SCALE_W = 16;
  localparam int unsigned PRE_LSB = 8;
  localparam int unsigned PRE_W   = 8;
  localparam int unsigned EXP_W   = 3;
  localparam logic [EXP_W-1:0] BYPASS_EXP = '1;
  // largest half period: 2^PRE_W << (2^EXP_W - 2)
  localparam int unsigned CNT_W   = PRE_W + (2**EXP_W - 2);
  localparam int unsigned N_CH    = 2;

  typedef struct packed {
    logic             bypass;
    logic [CNT_W-1:0] half_m1;
  } sck_cfg_t;
endpackage

// File: rtl/spi_sck_decode.sv
module spi_sck_decode
  import spi_sck_pkg::*;
(
  input  logic [PRE_W-1:0] pre_i,
  input  logic [EXP_W-1:0] exp_i,
  output sck_cfg_t         cfg_o
);
  logic [CNT_W:0] base;
  logic [CNT_W:0] half;

  always_comb begin
    base = {{(CNT_W + 1 - PRE_W){1'b0}}, pre_i} + 1'b1;
    half = base << exp_i;
    cfg_o.bypass  = (exp_i == BYPASS_EXP);
    cfg_o.half_m1 = half[CNT_W-1:0] - 1'b1;
  end
endmodule

// File: rtl/spi_sck_bypass_gate.sv
module spi_sck_bypass_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o
);
  logic gate_q;

  // gate changes while the parent clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= run_i;
  end

  assign sck_o = clk_i & gate_q & run_i;
endmodule

// File: rtl/spi_sck_channel.sv
module spi_sck_channel
  import spi_sck_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               sck_o,
  output logic               tick_o,
  output logic               rise_o,
  output logic               fall_o
);
  sck_cfg_t         dec_cfg;
  sck_cfg_t         cfg_q;
  logic             run_q;
  logic             sck_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             byp_run;
  logic             byp_sck;
  logic             unused_scale;

  assign unused_scale = ^scale_i[PRE_LSB-1:EXP_W];

  spi_sck_decode i_decode (
    .pre_i (scale_i[PRE_LSB +: PRE_W]),
    .exp_i (scale_i[EXP_W-1:0]),
    .cfg_o (dec_cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sck_q <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      sck_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      sck_q <= 1'b0;
      cnt_q <= '0;
      cfg_q <= dec_cfg;
    end else if (!cfg_q.bypass) begin
      if (cnt_q == cfg_q.half_m1) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign byp_run = run_q & cfg_q.bypass;
  assign hit     = run_q & ~cfg_q.bypass & (cnt_q == cfg_q.half_m1);

  spi_sck_bypass_gate i_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (byp_run),
    .sck_o  (byp_sck)
  );

  assign rise_o = hit & ~sck_q;
  assign fall_o = hit & sck_q;
  assign tick_o = fall_o | byp_run;
  assign sck_o  = cfg_q.bypass ? byp_sck : sck_q;
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_sck_pkg::*;
#(
  parameter bit SHARE_SCALE = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic [SCALE_W-1:0] tx_scale_i,
  input  logic               rx_en_i,
  input  logic [SCALE_W-1:0] rx_scale_i,
  output logic               tx_sck_o,
  output logic               tx_tick_o,
  output logic               tx_rise_o,
  output logic               tx_fall_o,
  output logic               rx_sck_o,
  output logic               rx_tick_o,
  output logic               rx_rise_o,
  output logic               rx_fall_o
);
  logic [N_CH-1:0]              en_v;
  logic [N_CH-1:0][SCALE_W-1:0] scale_v;
  logic [N_CH-1:0]              sck_v, tick_v, rise_v, fall_v;

  assign en_v[0]    = tx_en_i;
  assign scale_v[0] = tx_scale_i;

  if (SHARE_SCALE) begin : g_shared
    logic unused_rx;
    assign unused_rx  = rx_en_i ^ (^rx_scale_i);
    assign en_v[1]    = tx_en_i;
    assign scale_v[1] = tx_scale_i;
  end else begin : g_split
    assign en_v[1]    = rx_en_i;
    assign scale_v[1] = rx_scale_i;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    spi_sck_channel i_channel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_v[g]),
      .scale_i (scale_v[g]),
      .sck_o   (sck_v[g]),
      .tick_o  (tick_v[g]),
      .rise_o  (rise_v[g]),
      .fall_o  (fall_v[g])
    );
  end

  assign tx_sck_o  = sck_v[0];
  assign tx_tick_o = tick_v[0];
  assign tx_rise_o = rise_v[0];
  assign tx_fall_o = fall_v[0];
  assign rx_sck_o  = sck_v[1];
  assign rx_tick_o = tick_v[1];
  assign rx_rise_o = rise_v[1];
  assign rx_fall_o = fall_v[1];
endmodule

// File: rtl/spi_sck_prescaler_chk.sv
module spi_sck_prescaler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic rx_en_i,
  input logic tx_sck_o,
  input logic tx_tick_o,
  input logic tx_rise_o,
  input logic tx_fall_o,
  input logic rx_sck_o,
  input logic rx_tick_o,
  input logic rx_rise_o,
  input logic rx_fall_o
);
  logic [1:0] en, sck, tick, rise, fall;
  assign en   = {rx_en_i,   tx_en_i};
  assign sck  = {rx_sck_o,  tx_sck_o};
  assign tick = {rx_tick_o, tx_tick_o};
  assign rise = {rx_rise_o, tx_rise_o};
  assign fall = {rx_fall_o, tx_fall_o};

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R5
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rise[g], fall[g]}));
    // R5
    rise_then_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[g] && en[g] |=> sck[g]);
    // R5
    fall_then_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall[g] |=> !sck[g]);
    // R6
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en[g] |=> !sck[g] && !tick[g] && !rise[g] && !fall[g]);
    // R4
    level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en[g] && $past(en[g]) && !$past(rise[g]) && !$past(fall[g]) |-> $stable(sck[g]));
  end
endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk i_spi_sck_prescaler_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .rx_en_i   (rx_en_i),
  .tx_sck_o  (tx_sck_o),
  .tx_tick_o (tx_tick_o),
  .tx_rise_o (tx_rise_o),
  .tx_fall_o (tx_fall_o),
  .rx_sck_o  (rx_sck_o),
  .rx_tick_o (rx_tick_o),
  .rx_rise_o (rx_rise_o),
  .rx_fall_o (rx_fall_o)
);

// File: tb/test_spi_sck_prescaler.sv
module test_spi_sck_prescaler;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en_i = 1'b0, rx_en_i = 1'b0;
  logic [15:0] tx_scale_i = '0, rx_scale_i = '0;
  logic tx_sck_o, tx_tick_o, tx_rise_o, tx_fall_o;
  logic rx_sck_o, rx_tick_o, rx_rise_o, rx_fall_o;

  always #4 clk_i = ~clk_i;

  spi_sck_prescaler i_spi_sck_prescaler (.*);

  typedef struct {
    logic [3:0] v;  // {sck, tick, rise, fall}
    string      tag;
  } exp_t;

  exp_t q_tx[$];
  exp_t q_rx[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  function automatic logic [3:0] model(logic [15:0] code, int j);
    int h;
    logic s, hit;
    if (code[2:0] == 3'd7) return {(j > 0), 1'b1, 1'b0, 1'b0};
    h   = (int'(code[15:8]) + 1) << code[2:0];
    hit = ((j + 1) % h) == 0;
    s   = ((j / h) % 2) == 1;
    return {s, hit & s, hit & ~s, hit & s};
  endfunction

  task automatic push(int ch, logic [3:0] v, string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    if (ch == 0) q_tx.push_back(e);
    else         q_rx.push_back(e);
  endtask

  task automatic run_frame(int ch, logic [15:0] code, int len, string tag,
                           logic [15:0] alt = 16'h0, int alt_at = -1);
    @(negedge clk_i);
    if (ch == 0) begin tx_scale_i = code; tx_en_i = 1'b1; end
    else         begin rx_scale_i = code; rx_en_i = 1'b1; end
    for (int j = 0; j < len; j++) push(ch, model(code, j), tag);
    push(ch, 4'b0, "R6");
    push(ch, 4'b0, "R6");
    for (int j = 0; j < len; j++) begin
      @(negedge clk_i);
      if (j == alt_at) begin
        if (ch == 0) tx_scale_i = alt;
        else         rx_scale_i = alt;
      end
    end
    if (ch == 0) tx_en_i = 1'b0;
    else         rx_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic idle_span(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk_i);
      tx_scale_i = 16'h0007 ^ 16'(j);
      rx_scale_i = 16'h1F00 + 16'(j);
      push(0, 4'b0, "R6");
      push(1, 4'b0, "R6");
    end
    @(negedge clk_i);
  endtask

  always @(posedge clk_i) begin
    exp_t e;
    logic [3:0] got;
    #2;
    if (q_tx.size() > 0) begin
      e = q_tx.pop_front();
      got = {tx_sck_o, tx_tick_o, tx_rise_o, tx_fall_o};
      n_chk++;
      if (got !== e.v) begin
        n_bad++;
        $display("FAIL %s tx got %b exp %b", e.tag, got, e.v);
      end
    end
    if (q_rx.size() > 0) begin
      e = q_rx.pop_front();
      got = {rx_sck_o, rx_tick_o, rx_rise_o, rx_fall_o};
      n_chk++;
      if (got !== e.v) begin
        n_bad++;
        $display("FAIL %s rx got %b exp %b", e.tag, got, e.v);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got %0d cycles exp fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #13;
    n_chk++;  // R6 reset state
    if ({tx_sck_o, tx_tick_o, tx_rise_o, tx_fall_o, rx_sck_o, rx_tick_o, rx_rise_o, rx_fall_o} !== 8'b0) begin
      n_bad++;
      $display("FAIL R6 reset got %b exp 0", {tx_sck_o, tx_tick_o, tx_rise_o, tx_fall_o});
    end
    rst_ni = 1'b1;
    idle_span(6);                                  // R6
    run_frame(0, 16'h0000, 12, "R3");              // R3 div 2
    run_frame(0, 16'h0001, 20, "R4");              // R4 div 4
    run_frame(0, 16'h0007, 6, "R1");               // R1 bypass
    run_frame(0, 16'hFF07, 5, "R1");               // R1 upper byte ignored
    run_frame(0, 16'h0004, 100, "R3");             // R3 div 32
    run_frame(0, 16'h1F00, 200, "R3");             // R3 div 64
    run_frame(0, 16'h1F04, 2100, "R3");            // R3 div 1024
    run_frame(0, 16'h00F9, 24, "R2");              // R2 bits 7:3 ignored
    run_frame(0, 16'h0506, 800, "R2");             // R2 div 768
    run_frame(0, 16'h0302, 70, "R7", 16'h0000, 10);// R7 mid-frame change
    run_frame(1, 16'h0007, 4, "R7", 16'h0004, 1);  // R7 bypass kept
    run_frame(0, 16'h0002, 13, "R6");              // R6 abort mid-period
    run_frame(0, 16'h0002, 16, "R5");              // R5 restart from zero
    run_frame(1, 16'h1F01, 300, "R3");             // R3 div 128 on rx
    fork                                           // R8 independent channels
      run_frame(0, 16'h0001, 40, "R8");
      run_frame(1, 16'h0003, 60, "R8");
    join
    idle_span(3);
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule